// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block drives the memory side of one channel of a memory-to-memory DMA engine. A single `start` pulse captures the source address, destination address, the two beat widths, the two address stepping modes, a burst-size code and a transfer count. The block then issues read beats and write beats on a request/grant memory port until the count is used up. Each request is held until it is granted. The count is kept in source-width units and can be read at any time.

Reads are gathered into bursts whose length is a power of two. After each read burst, the bytes collected so far are written out as whole destination-width beats. Then the next burst starts. The block ends a job with a one-cycle terminal-count pulse or a one-cycle abort pulse. A configuration it cannot run gives a one-cycle error pulse, and in that case no beat is issued. Misaligned addresses are rejected with this error pulse. The block never splits them into smaller accesses.

Top module: `dma_addr_seq`

## Requirements
- R1: Width codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes per beat. `mem_size` carries the width code of the side being accessed: the source code for reads (`mem_we`=0) and the destination code for writes (`mem_we`=1).
- R2: Stepping code 0 raises the address by the beat width in bytes after each granted beat on that side. Code 1 lowers it by the same amount. Code 2 leaves it unchanged. The source and destination codes are independent.
- R3: `remaining` is loaded with the count when a valid job starts. It drops by one on every granted read beat and is readable at all times, including while a job runs.
- R4: With burst code n, reads come in bursts of min(2^n, remaining) beats. After each burst, every whole destination-width beat of the collected bytes is written before the next burst begins. Total bytes equal the count times the source width.
- R5: Once `mem_req` is high, it stays high with `mem_addr`, `mem_we` and `mem_size` unchanged until the cycle in which `mem_gnt` is high.
- R6: Any of the following raises `err_pulse` for one cycle, in the cycle after `start`: a width code above 3, a stepping code of 3, a burst code above 10, or a misaligned address. An address is misaligned when bit 0 is set for a half-word, when bits 1:0 are not zero for a word, or when bits 2:0 are not zero for a double word. A count times source bytes that is not a multiple of the destination bytes has the same effect. In every one of these cases no beat is issued and `busy` stays low.
- R7: `tc_pulse` is high for one cycle, in the cycle after the final beat is granted. `busy` falls in that same cycle. A valid start with a count of zero gives `tc_pulse` in the next cycle and issues no beat.
- R8: When `abort_req` is high during a job, the job ends at the grant of the beat in flight. No further beat is issued, `abort_pulse` replaces `tc_pulse`, and `remaining` keeps its value. `abort_req` while idle has no effect.
- R9: A `start` while a job is running is ignored.
- R10: At most one of `tc_pulse`, `err_pulse` and `abort_pulse` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job with the cfg_* values |
| cfg_src_addr | input | AW | Source start address |
| cfg_dst_addr | input | AW | Destination start address |
| cfg_src_width | input | 3 | Source width code |
| cfg_dst_width | input | 3 | Destination width code |
| cfg_src_step | input | 2 | Source stepping code |
| cfg_dst_step | input | 2 | Destination stepping code |
| cfg_burst_code | input | 4 | Log2 of the read burst length |
| cfg_count | input | CW | Transfer count in source-width units |
| abort_req | input | 1 | Stop the running job at the next beat boundary |
| mem_req | output | 1 | Beat request |
| mem_we | output | 1 | 1 for a write beat, 0 for a read beat |
| mem_addr | output | AW | Beat address |
| mem_size | output | 2 | Beat width code |
| mem_gnt | input | 1 | Beat accepted this cycle |
| remaining | output | CW | Source-width beats left to read |
| busy | output | 1 | A job is running |
| tc_pulse | output | 1 | Job finished (one cycle) |
| err_pulse | output | 1 | Configuration rejected (one cycle) |
| abort_pulse | output | 1 | Job aborted (one cycle) |

## Verification
The assertions check four properties on every cycle: that a request stays stable until it is granted, that every issued address is aligned to its beat width, that a granted read lowers the count by exactly one, and that the three end pulses never overlap. They also check that the error and abort pulses leave no request behind, and that a fixed-mode address never moves. Some behaviour can only be shown by the bench's scenarios: the order of reads and writes across bursts when the two widths differ, the exact address sequence under each stepping mode, and the cycle in which terminal count or abort appears. The same holds for rejecting each kind of bad configuration, and for ignoring a start during a job or an abort while idle.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_READ  = 2'd1,
      SEQ_WRITE = 2'd2
   } seq_state_e;

   localparam logic [1:0] STEP_UP   = 2'd0;
   localparam logic [1:0] STEP_DOWN = 2'd1;
   localparam logic [1:0] STEP_HOLD = 2'd2;

   // Low-address-bit mask that must be clear for a given width code.
   function automatic logic [2:0] align_mask(input logic [1:0] code);
      case (code)
         2'd0:    return 3'b000;
         2'd1:    return 3'b001;
         2'd2:    return 3'b011;
         default: return 3'b111;
      endcase
   endfunction

endpackage

// File: rtl/dma_seq_cfg_check.sv
module dma_seq_cfg_check
   import dma_seq_pkg::*;
#(
   parameter int AW            = 32,
   parameter int CW            = 16,
   parameter int MAX_BURST_LOG = 10
) (
   input  logic [AW-1:0] src_addr,
   input  logic [AW-1:0] dst_addr,
   input  logic [2:0]    src_width,
   input  logic [2:0]    dst_width,
   input  logic [1:0]    src_step,
   input  logic [1:0]    dst_step,
   input  logic [3:0]    burst_code,
   input  logic [CW-1:0] count,
   output logic          cfg_bad
);

   logic       width_bad;
   logic       step_bad;
   logic       burst_bad;
   logic       src_misal;
   logic       dst_misal;
   logic       total_bad;
   logic [5:0] total_low;

   always_comb begin
      width_bad = src_width[2] | dst_width[2];
      step_bad  = (src_step == 2'd3) | (dst_step == 2'd3);
      burst_bad = (burst_code > 4'(MAX_BURST_LOG));
      src_misal = |(src_addr[2:0] & align_mask(src_width[1:0]));
      dst_misal = |(dst_addr[2:0] & align_mask(dst_width[1:0]));
      // only the low three bits of count * source bytes decide divisibility
      total_low = {3'b000, count[2:0]} << src_width[1:0];
      total_bad = |(total_low[2:0] & align_mask(dst_width[1:0]));
      cfg_bad   = width_bad | step_bad | burst_bad | src_misal | dst_misal | total_bad;
   end

endmodule

// File: rtl/dma_seq_addr_gen.sv
module dma_seq_addr_gen
   import dma_seq_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_addr,
   input  logic [1:0]    load_step,
   input  logic [1:0]    load_width,
   input  logic          advance,
   output logic [AW-1:0] addr
);

   logic [1:0]    step_q;
   logic [1:0]    width_q;
   logic [AW-1:0] stride;

   assign stride = AW'(1) << width_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr    <= '0;
         step_q  <= STEP_UP;
         width_q <= 2'd0;
      end else if (load) begin
         addr    <= load_addr;
         step_q  <= load_step;
         width_q <= load_width;
      end else if (advance) begin
         case (step_q)
            STEP_UP:   addr <= addr + stride;
            STEP_DOWN: addr <= addr - stride;
            default:   addr <= addr;
         endcase
      end
   end

   // R2: a fixed-mode side never moves
   a_r2_fixed_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (!load && step_q == STEP_HOLD) |=> $stable(addr));

   // R2: the address moves only on a granted beat of this side
   a_r2_idle_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !advance) |=> $stable(addr));

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
   import dma_seq_pkg::*;
#(
   parameter int CW            = 16,
   parameter int MAX_BURST_LOG = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          cfg_bad,
   input  logic [CW-1:0] count_in,
   input  logic [3:0]    burst_in,
   input  logic [1:0]    src_w_in,
   input  logic [1:0]    dst_w_in,
   input  logic          abort_req,
   input  logic          mem_gnt,
   output logic          mem_req,
   output logic          mem_we,
   output logic [1:0]    src_w,
   output logic [1:0]    dst_w,
   output logic          load,
   output logic          adv_src,
   output logic          adv_dst,
   output logic [CW-1:0] remaining,
   output logic          busy,
   output logic          tc_pulse,
   output logic          err_pulse,
   output logic          abort_pulse
);

   localparam int CRW = MAX_BURST_LOG + 5;

   initial begin
      assert (CW >= MAX_BURST_LOG + 2) else $error("count width too small for burst length");
      assert (MAX_BURST_LOG <= 14) else $error("burst code is only four bits wide");
   end

   seq_state_e     state;
   logic [CW-1:0]  blen_left;
   logic [CRW-1:0] credit;
   logic [3:0]     bcode_q;
   logic           abort_pend;

   logic           fire;
   logic [CW-1:0]  rem_nx;
   logic [CRW-1:0] credit_nx;
   logic [CRW-1:0] src_bytes;
   logic [CRW-1:0] dst_bytes;
   logic           stop_now;

   function automatic logic [CW-1:0] burst_limit(input logic [CW-1:0] left,
                                                 input logic [3:0]    code);
      logic [CW-1:0] full;
      full = CW'(1) << code;
      return (left < full) ? left : full;
   endfunction

   assign mem_req  = (state != SEQ_IDLE);
   assign mem_we   = (state == SEQ_WRITE);
   assign busy     = mem_req;
   assign fire     = mem_req & mem_gnt;
   assign load     = (state == SEQ_IDLE) & start & ~cfg_bad;
   assign adv_src  = fire & (state == SEQ_READ);
   assign adv_dst  = fire & (state == SEQ_WRITE);
   assign stop_now = abort_pend | abort_req;

   always_comb begin
      src_bytes = CRW'(1) << src_w;
      dst_bytes = CRW'(1) << dst_w;
      rem_nx    = remaining;
      credit_nx = credit;
      if (adv_src) begin
         rem_nx    = remaining - CW'(1);
         credit_nx = credit + src_bytes;
      end else if (adv_dst) begin
         credit_nx = credit - dst_bytes;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= SEQ_IDLE;
         remaining   <= '0;
         blen_left   <= '0;
         credit      <= '0;
         bcode_q     <= '0;
         src_w       <= '0;
         dst_w       <= '0;
         abort_pend  <= 1'b0;
         tc_pulse    <= 1'b0;
         err_pulse   <= 1'b0;
         abort_pulse <= 1'b0;
      end else begin
         tc_pulse    <= 1'b0;
         err_pulse   <= 1'b0;
         abort_pulse <= 1'b0;
         if (state == SEQ_IDLE) begin
            abort_pend <= 1'b0;
            if (start) begin
               if (cfg_bad) begin
                  err_pulse <= 1'b1;
               end else begin
                  remaining <= count_in;
                  credit    <= '0;
                  bcode_q   <= burst_in;
                  src_w     <= src_w_in;
                  dst_w     <= dst_w_in;
                  blen_left <= burst_limit(count_in, burst_in);
                  if (count_in == '0) tc_pulse <= 1'b1;
                  else                state    <= SEQ_READ;
               end
            end
         end else begin
            if (abort_req) abort_pend <= 1'b1;
            if (fire) begin
               remaining <= rem_nx;
               credit    <= credit_nx;
               if (stop_now) begin
                  state       <= SEQ_IDLE;
                  abort_pulse <= 1'b1;
               end else if (state == SEQ_READ && blen_left != CW'(1)) begin
                  blen_left <= blen_left - CW'(1);
               end else if (credit_nx >= dst_bytes) begin
                  state <= SEQ_WRITE;
               end else if (rem_nx == '0) begin
                  state    <= SEQ_IDLE;
                  tc_pulse <= 1'b1;
               end else begin
                  state     <= SEQ_READ;
                  blen_left <= burst_limit(rem_nx, bcode_q);
               end
            end
         end
      end
   end

   // R3: a granted read lowers the count by exactly one
   a_r3_read_decrements : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_gnt && !mem_we) |=> (remaining == $past(remaining) - CW'(1)));

   // R7: terminal count only with nothing left and the channel idle
   a_r7_tc_at_zero : assert property (@(posedge clk) disable iff (!rst_n)
      tc_pulse |-> (remaining == '0 && !busy));

   // R6: a rejected job leaves the channel idle
   a_r6_err_idle : assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> (!busy && !mem_req));

   // R8: nothing is requested once the abort has taken effect
   a_r8_abort_stops : assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |-> !mem_req);

   // R10: end pulses are exclusive
   a_r10_one_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tc_pulse, err_pulse, abort_pulse}));

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
   import dma_seq_pkg::*;
#(
   parameter int AW            = 32,
   parameter int CW            = 16,
   parameter int MAX_BURST_LOG = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] cfg_src_addr,
   input  logic [AW-1:0] cfg_dst_addr,
   input  logic [2:0]    cfg_src_width,
   input  logic [2:0]    cfg_dst_width,
   input  logic [1:0]    cfg_src_step,
   input  logic [1:0]    cfg_dst_step,
   input  logic [3:0]    cfg_burst_code,
   input  logic [CW-1:0] cfg_count,
   input  logic          abort_req,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [1:0]    mem_size,
   input  logic          mem_gnt,
   output logic [CW-1:0] remaining,
   output logic          busy,
   output logic          tc_pulse,
   output logic          err_pulse,
   output logic          abort_pulse
);

   localparam int NSIDE = 2;

   initial begin
      assert (AW >= 4) else $error("address width too small");
   end

   logic          cfg_bad;
   logic          load;
   logic          adv_src;
   logic          adv_dst;
   logic [1:0]    src_w;
   logic [1:0]    dst_w;

   logic [AW-1:0] side_start [NSIDE];
   logic [1:0]    side_step  [NSIDE];
   logic [1:0]    side_width [NSIDE];
   logic          side_adv   [NSIDE];
   logic [AW-1:0] side_addr  [NSIDE];

   dma_seq_cfg_check #(.AW(AW), .CW(CW), .MAX_BURST_LOG(MAX_BURST_LOG)) u_check (
      .src_addr   (cfg_src_addr),
      .dst_addr   (cfg_dst_addr),
      .src_width  (cfg_src_width),
      .dst_width  (cfg_dst_width),
      .src_step   (cfg_src_step),
      .dst_step   (cfg_dst_step),
      .burst_code (cfg_burst_code),
      .count      (cfg_count),
      .cfg_bad    (cfg_bad)
   );

   dma_seq_ctrl #(.CW(CW), .MAX_BURST_LOG(MAX_BURST_LOG)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .cfg_bad     (cfg_bad),
      .count_in    (cfg_count),
      .burst_in    (cfg_burst_code),
      .src_w_in    (cfg_src_width[1:0]),
      .dst_w_in    (cfg_dst_width[1:0]),
      .abort_req   (abort_req),
      .mem_gnt     (mem_gnt),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .src_w       (src_w),
      .dst_w       (dst_w),
      .load        (load),
      .adv_src     (adv_src),
      .adv_dst     (adv_dst),
      .remaining   (remaining),
      .busy        (busy),
      .tc_pulse    (tc_pulse),
      .err_pulse   (err_pulse),
      .abort_pulse (abort_pulse)
   );

   assign side_start[0] = cfg_src_addr;
   assign side_start[1] = cfg_dst_addr;
   assign side_step[0]  = cfg_src_step;
   assign side_step[1]  = cfg_dst_step;
   assign side_width[0] = cfg_src_width[1:0];
   assign side_width[1] = cfg_dst_width[1:0];
   assign side_adv[0]   = adv_src;
   assign side_adv[1]   = adv_dst;

   for (genvar s = 0; s < NSIDE; s++) begin : g_side
      dma_seq_addr_gen #(.AW(AW)) u_gen (
         .clk        (clk),
         .rst_n      (rst_n),
         .load       (load),
         .load_addr  (side_start[s]),
         .load_step  (side_step[s]),
         .load_width (side_width[s]),
         .advance    (side_adv[s]),
         .addr       (side_addr[s])
      );
   end

   assign mem_addr = mem_we ? side_addr[1] : side_addr[0];
   assign mem_size = mem_we ? dst_w : src_w;

   // R5: a pending request holds still until granted
   a_r5_req_stable : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_size)));

   // R1: every issued beat is aligned to its own width
   a_r1_beat_aligned : assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ((mem_addr[2:0] & align_mask(mem_size)) == 3'b000));

endmodule

// File: tb/dma_addr_seq_tb.sv
module dma_addr_seq_tb_top;

   localparam int AW = 32;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] c_saddr = '0;
   logic [AW-1:0] c_daddr = '0;
   logic [2:0]    c_sw = '0;
   logic [2:0]    c_dw = '0;
   logic [1:0]    c_sm = '0;
   logic [1:0]    c_dm = '0;
   logic [3:0]    c_burst = '0;
   logic [CW-1:0] c_count = '0;
   logic          abort_req = 1'b0;
   logic          mem_gnt = 1'b0;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [1:0]    mem_size;
   logic [CW-1:0] remaining;
   logic          busy, tc_pulse, err_pulse, abort_pulse;

   always #5 clk = ~clk;

   dma_addr_seq #(.AW(AW), .CW(CW), .MAX_BURST_LOG(10)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_src_addr(c_saddr), .cfg_dst_addr(c_daddr),
      .cfg_src_width(c_sw), .cfg_dst_width(c_dw),
      .cfg_src_step(c_sm), .cfg_dst_step(c_dm),
      .cfg_burst_code(c_burst), .cfg_count(c_count),
      .abort_req(abort_req),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
      .mem_gnt(mem_gnt),
      .remaining(remaining), .busy(busy),
      .tc_pulse(tc_pulse), .err_pulse(err_pulse), .abort_pulse(abort_pulse)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int tc_seen = 0;

   // stimulus requests (written by the scenario process just after a rising edge)
   bit go = 0;
   bit gnt_rand = 0;
   bit idle_abort = 0;
   int abort_after = -1;

   // reference model
   logic [34:0]   q[$];
   bit            m_busy = 0;
   logic [CW-1:0] m_rem = '0;
   bit            e_tc = 0, e_err = 0, e_abt = 0;
   bit            abort_seen = 0;
   int            gcnt = 0;
   bit            h_valid = 0;
   logic [AW-1:0] h_addr = '0;
   logic          h_we = 0;
   logic [15:0]   lfsr = 16'hACE1;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit cfg_invalid();
      int sb, db;
      if (c_sw > 3 || c_dw > 3) return 1;
      if (c_sm == 3 || c_dm == 3) return 1;
      if (c_burst > 10) return 1;
      sb = 1 << c_sw;
      db = 1 << c_dw;
      if ((c_saddr % sb) != 0) return 1;
      if ((c_daddr % db) != 0) return 1;
      if (((int'(c_count) * sb) % db) != 0) return 1;
      return 0;
   endfunction

   function automatic logic [AW-1:0] stepped(input logic [AW-1:0] a, input logic [1:0] m, input int b);
      if (m == 0) return a + AW'(b);
      if (m == 1) return a - AW'(b);
      return a;
   endfunction

   task automatic build_queue();
      logic [AW-1:0] sa, da;
      int rem, credit, sb, db, blen, n;
      sa = c_saddr; da = c_daddr; rem = int'(c_count); credit = 0;
      sb = 1 << c_sw; db = 1 << c_dw; blen = 1 << c_burst;
      q.delete();
      while (rem > 0) begin
         n = (rem < blen) ? rem : blen;
         for (int i = 0; i < n; i++) begin
            q.push_back({1'b0, c_sw[1:0], sa});
            sa = stepped(sa, c_sm, sb);
            credit += sb;
            rem--;
         end
         while (credit >= db) begin
            q.push_back({1'b1, c_dw[1:0], da});
            da = stepped(da, c_dm, db);
            credit -= db;
         end
      end
   endtask

   always @(negedge clk) begin
      logic [34:0] head;
      bit start_d, abort_d, gnt_d;
      if (rst_n) begin
         // compare the outputs settled since the last rising edge
         chk(busy === m_busy, "R7 busy", 64'(busy), 64'(m_busy));
         chk(remaining === m_rem, "R3 remaining", 64'(remaining), 64'(m_rem));
         chk(mem_req === m_busy, "R4 request", 64'(mem_req), 64'(m_busy));
         chk(tc_pulse === e_tc, "R7 terminal count", 64'(tc_pulse), 64'(e_tc));
         chk(err_pulse === e_err, "R6 error pulse", 64'(err_pulse), 64'(e_err));
         chk(abort_pulse === e_abt, "R8 abort pulse", 64'(abort_pulse), 64'(e_abt));
         chk($onehot0({tc_pulse, err_pulse, abort_pulse}), "R10 exclusive pulses",
             64'({tc_pulse, err_pulse, abort_pulse}), 64'(0));
         if (h_valid)
            chk(mem_req === 1'b1 && mem_addr === h_addr && mem_we === h_we, "R5 held request",
                64'(mem_addr), 64'(h_addr));
         if (tc_pulse) tc_seen++;

         // drive inputs for the coming edge
         lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         gnt_d   = gnt_rand ? (lfsr[0] | lfsr[5]) : 1'b1;
         start_d = go;
         go      = 0;
         abort_d = 0;
         if (m_busy && abort_after >= 0 && gcnt == abort_after) abort_d = 1;
         if (!m_busy && idle_abort) begin abort_d = 1; idle_abort = 0; end
         start     = start_d;
         abort_req = abort_d;
         mem_gnt   = gnt_d;
         h_valid   = mem_req && !gnt_d;
         h_addr    = mem_addr;
         h_we      = mem_we;

         // predict the effect of the coming edge
         e_tc = 0; e_err = 0; e_abt = 0;
         if (m_busy) begin
            if (abort_d) abort_seen = 1;
            if (gnt_d) begin
               if (q.size() == 0) begin
                  chk(0, "R4 unexpected beat", 64'(mem_addr), 64'(0));
               end else begin
                  head = q.pop_front();
                  chk(mem_addr === head[31:0], "R2 beat address", 64'(mem_addr), 64'(head[31:0]));
                  chk(mem_size === head[33:32], "R1 beat size", 64'(mem_size), 64'(head[33:32]));
                  chk(mem_we === head[34], "R4 beat order", 64'(mem_we), 64'(head[34]));
                  if (!head[34]) m_rem = m_rem - 1'b1;
               end
               gcnt++;
               if (abort_seen) begin
                  m_busy = 0; e_abt = 1; q.delete(); abort_after = -1;
               end else if (q.size() == 0) begin
                  m_busy = 0; e_tc = 1;
               end
            end
         end else if (start_d) begin
            if (cfg_invalid()) e_err = 1;
            else if (c_count == 0) begin m_rem = '0; e_tc = 1; end
            else begin
               build_queue();
               m_busy = 1; m_rem = c_count; abort_seen = 0; gcnt = 0;
            end
         end
      end
   end

   task automatic set_cfg(input logic [31:0] sa, input logic [31:0] da, input logic [2:0] sw,
                          input logic [2:0] dw, input logic [1:0] sm, input logic [1:0] dm,
                          input logic [3:0] b, input logic [15:0] n);
      c_saddr = sa; c_daddr = da; c_sw = sw; c_dw = dw;
      c_sm = sm; c_dm = dm; c_burst = b; c_count = n;
   endtask

   task automatic launch();
      @(posedge clk); #1;
      go = 1;
   endtask

   task automatic wait_done();
      do begin @(posedge clk); #1; end while (go || m_busy);
      repeat (3) @(posedge clk);
      #1;
   endtask

   task automatic run_job();
      launch();
      wait_done();
      chk(q.size() == 0, "R4 all beats issued", 64'(q.size()), 64'(0));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R7 watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : scenarios
      int tc_before;
      repeat (3) @(posedge clk);
      #1;
      chk(busy === 0 && mem_req === 0, "R7 reset idle", 64'({busy, mem_req}), 64'(0));
      chk(remaining === '0, "R3 reset count", 64'(remaining), 64'(0));
      rst_n = 1;
      repeat (2) @(posedge clk);
      #1;

      // R2 R4: word to word, both incrementing, bursts of 4
      set_cfg(32'h1000, 32'h2000, 3'd2, 3'd2, 2'd0, 2'd0, 4'd2, 16'd6);
      run_job();

      // R1 R4: bytes gathered into a fixed word destination, random grants
      gnt_rand = 1;
      set_cfg(32'h3001, 32'h4000, 3'd0, 3'd2, 2'd0, 2'd2, 4'd1, 16'd8);
      run_job();

      // R2: double words downward split into decrementing half words
      set_cfg(32'h5000, 32'h6000, 3'd3, 3'd1, 2'd1, 2'd1, 4'd0, 16'd3);
      run_job();

      // R4: burst code larger than the count, fixed half-word source
      set_cfg(32'h7002, 32'h8003, 3'd1, 3'd0, 2'd2, 2'd0, 4'd10, 16'd5);
      run_job();

      // R6: each rejected configuration
      set_cfg(32'h1000, 32'h2000, 3'd4, 3'd2, 2'd0, 2'd0, 4'd0, 16'd4); run_job();
      set_cfg(32'h1001, 32'h2000, 3'd1, 3'd1, 2'd0, 2'd0, 4'd0, 16'd4); run_job();
      set_cfg(32'h1000, 32'h2002, 3'd2, 3'd2, 2'd0, 2'd0, 4'd0, 16'd4); run_job();
      set_cfg(32'h1004, 32'h2000, 3'd3, 3'd0, 2'd0, 2'd0, 4'd0, 16'd4); run_job();
      set_cfg(32'h1000, 32'h2000, 3'd0, 3'd0, 2'd3, 2'd0, 4'd0, 16'd4); run_job();
      set_cfg(32'h1000, 32'h2000, 3'd0, 3'd0, 2'd0, 2'd0, 4'd11, 16'd4); run_job();
      set_cfg(32'h1000, 32'h2000, 3'd0, 3'd2, 2'd0, 2'd0, 4'd0, 16'd3); run_job();

      // R7: zero count ends at once
      set_cfg(32'h1000, 32'h2000, 3'd2, 3'd2, 2'd0, 2'd0, 4'd0, 16'd0);
      run_job();

      // R8: abort after three grants, count held
      set_cfg(32'h1000, 32'h2000, 3'd2, 3'd2, 2'd0, 2'd0, 4'd1, 16'd10);
      abort_after = 3;
      run_job();
      chk(remaining !== 16'd0, "R8 count kept", 64'(remaining), 64'(m_rem));

      // R8: abort while idle has no effect on the next job
      idle_abort = 1;
      repeat (3) @(posedge clk);
      #1;
      set_cfg(32'h1100, 32'h2100, 3'd1, 3'd1, 2'd0, 2'd0, 4'd0, 16'd2);
      run_job();

      // R9: a second start during a job is ignored
      tc_before = tc_seen;
      set_cfg(32'h1200, 32'h2200, 3'd0, 3'd0, 2'd0, 2'd1, 4'd0, 16'd6);
      launch();
      repeat (4) @(posedge clk);
      #1;
      set_cfg(32'h1300, 32'h2300, 3'd2, 3'd2, 2'd0, 2'd0, 4'd0, 16'd2);
      go = 1;
      wait_done();
      chk(tc_seen - tc_before == 1 && remaining === 16'd0, "R9 start ignored while busy",
          64'(tc_seen - tc_before), 64'(1));

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule